// File: doc/BRIEF.md
# Platform System Control Register Block

This block is a byte-wide I/O-port register file for a legacy platform controller. It claims port 0x92, the scratch pair 0x398/0x399 and the window 0x800 to 0x851. Reads return either fixed identification bytes or the stored control values, and any unassigned port inside a claimed range reads as 0xFF. Writes have side effects. They drive a soft-reset level, a disk-activity indicator, a 4-bit system-control field and one-cycle strobes for two NVRAM lock toggles and an L2 invalidate.

The block also holds the I/O map-mode bit. A translator uses this bit to turn an offset inside the 8 MB CPU I/O window into a 16-bit ISA port address. With the bit clear, the low 16 bits are passed through unchanged, giving a 64 KB contiguous space. With the bit set, a sparse scheme is used in which every 4 KB page of the window carries 32 ports.

Read data and the translated address are combinational functions of the inputs and the stored state. Every write takes effect at the rising clock edge on which `port_wr` is sampled high.

Top module: `sysctl_regblk`

## Requirements
- R1: After reset, soft_reset, disk_led, map_sparse, sysctl_nibble, lock1_pulse, lock2_pulse and l2_inval_pulse are all 0, and the two scratch bytes read 0x00.
- R2: A write to port 0x92 sets soft_reset to bit 0 of the written byte from the next edge onward. A read of 0x92 returns 0x01 when soft_reset is set and 0x00 when it is clear.
- R3: Reads of the identification ports return fixed bytes: 0x800 returns 0xEF, 0x802 returns 0xAD, 0x803 returns 0xE0, 0x804 returns 0x39 and 0x818 returns 0x03. Writes to these ports change nothing.
- R4: A write to 0x81C stores bits 3:0 of the data on sysctl_nibble. A read of 0x81C returns that nibble with bits 7:4 as zero.
- R5: A write to 0x850 stores bit 0 of the data as map_sparse. A read of 0x850 returns 0x00 or 0x01.
- R6: While map_sparse is 0, isa_port equals win_addr[15:0].
- R7: While map_sparse is 1, isa_port equals {win_addr[22:12], win_addr[4:0]}. This is the window offset with bits 26:12 masked and shifted right by 7, OR'd with bits 4:0.
- R8: A write to 0x808 sets disk_led if the data is nonzero and clears it if the data is zero. A read of 0x808 returns 0x01 or 0x00 to match.
- R9: A write to 0x810 raises lock1_pulse, a write to 0x812 raises lock2_pulse and a write to 0x814 raises l2_inval_pulse. Each pulse is high for exactly the one cycle after the accepting edge, and no two pulses are ever high together.
- R10: Ports 0x398 and 0x399 each store a full written byte and return it on read.
- R11: port_hit is 1 only for 0x92, 0x398, 0x399 and 0x800 to 0x851. Every other port in those ranges, including 0x810, 0x812 and 0x814, reads 0xFF. Unclaimed ports also read 0xFF. Writes to unassigned ports leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_addr | input | 16 | I/O port address of the current access |
| port_wr | input | 1 | Write strobe, accepted at the rising edge |
| port_wdata | input | 8 | Write data byte |
| port_rdata | output | 8 | Read data byte for port_addr |
| port_hit | output | 1 | port_addr is claimed by this block |
| win_addr | input | 23 | Offset inside the 8 MB CPU I/O window |
| isa_port | output | 16 | Translated ISA port address |
| map_sparse | output | 1 | Stored map-mode bit |
| soft_reset | output | 1 | Soft-reset request level |
| disk_led | output | 1 | Disk-activity indicator flag |
| sysctl_nibble | output | 4 | Stored system-control field |
| lock1_pulse | output | 1 | NVRAM region 1 lock-toggle strobe |
| lock2_pulse | output | 1 | NVRAM region 2 lock-toggle strobe |
| l2_inval_pulse | output | 1 | L2 invalidate strobe |

## Verification
The two functions that can meet in one cycle are a write of the map-type port and an address translation. The bench drives a write of 1 to 0x850 while win_addr holds a pattern whose contiguous and sparse results differ. During the write cycle it expects the contiguous result, and after the accepting edge it expects the sparse result. In the random phase, translations are also interleaved with writes that toggle the mode, and each result is judged against the mode the model held at the time of the sample.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int PORT_W = 16;
  localparam int DATA_W = 8;
  localparam int WIN_W  = 23;
  localparam int NIB_W  = 4;

  localparam logic [PORT_W-1:0] P_RESET   = 16'h0092;
  localparam logic [PORT_W-1:0] P_SCR0    = 16'h0398;
  localparam logic [PORT_W-1:0] P_SCR1    = 16'h0399;
  localparam logic [PORT_W-1:0] P_WIN_LO  = 16'h0800;
  localparam logic [PORT_W-1:0] P_WIN_HI  = 16'h0851;
  localparam logic [PORT_W-1:0] P_CPUCFG  = 16'h0800;
  localparam logic [PORT_W-1:0] P_FEAT    = 16'h0802;
  localparam logic [PORT_W-1:0] P_STAT    = 16'h0803;
  localparam logic [PORT_W-1:0] P_XFEAT   = 16'h0804;
  localparam logic [PORT_W-1:0] P_LED     = 16'h0808;
  localparam logic [PORT_W-1:0] P_LOCK1   = 16'h0810;
  localparam logic [PORT_W-1:0] P_LOCK2   = 16'h0812;
  localparam logic [PORT_W-1:0] P_L2INV   = 16'h0814;
  localparam logic [PORT_W-1:0] P_L2STAT  = 16'h0818;
  localparam logic [PORT_W-1:0] P_SYSCTL  = 16'h081C;
  localparam logic [PORT_W-1:0] P_MAP     = 16'h0850;

  localparam logic [DATA_W-1:0] ID_CPUCFG = 8'hEF;
  localparam logic [DATA_W-1:0] ID_FEAT   = 8'hAD;
  localparam logic [DATA_W-1:0] ID_STAT   = 8'hE0;
  localparam logic [DATA_W-1:0] ID_XFEAT  = 8'h39;
  localparam logic [DATA_W-1:0] ID_L2STAT = 8'h03;
  localparam logic [DATA_W-1:0] RD_EMPTY  = 8'hFF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RSVD, SEL_RESET, SEL_SCR0, SEL_SCR1,
    SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_XFEAT, SEL_LED,
    SEL_LOCK1, SEL_LOCK2, SEL_L2INV, SEL_L2STAT, SEL_SYSCTL, SEL_MAP
  } sel_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [PORT_W-1:0] port_addr,
  output sel_e              sel,
  output logic              hit
);
  always_comb begin
    sel = SEL_NONE;
    if (port_addr >= P_WIN_LO && port_addr <= P_WIN_HI) begin
      sel = SEL_RSVD;
    end
    unique case (port_addr)
      P_RESET:  sel = SEL_RESET;
      P_SCR0:   sel = SEL_SCR0;
      P_SCR1:   sel = SEL_SCR1;
      P_CPUCFG: sel = SEL_CPUCFG;
      P_FEAT:   sel = SEL_FEAT;
      P_STAT:   sel = SEL_STAT;
      P_XFEAT:  sel = SEL_XFEAT;
      P_LED:    sel = SEL_LED;
      P_LOCK1:  sel = SEL_LOCK1;
      P_LOCK2:  sel = SEL_LOCK2;
      P_L2INV:  sel = SEL_L2INV;
      P_L2STAT: sel = SEL_L2STAT;
      P_SYSCTL: sel = SEL_SYSCTL;
      P_MAP:    sel = SEL_MAP;
      default:  ;
    endcase
  end

  assign hit = (sel != SEL_NONE);
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int NSCR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_e              sel,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rst_q,
  output logic              led_q,
  output logic [NIB_W-1:0]  nib_q,
  output logic              map_q,
  output logic [DATA_W-1:0] scr_q [NSCR],
  output logic              lock1_q,
  output logic              lock2_q,
  output logic              l2inv_q
);
  logic              rst_d, led_d, map_d;
  logic [NIB_W-1:0]  nib_d;
  logic [DATA_W-1:0] scr_d [NSCR];
  logic              lock1_d, lock2_d, l2inv_d;
  logic              scr_we [NSCR];

  genvar gi;
  generate
    for (gi = 0; gi < NSCR; gi++) begin : g_scr
      assign scr_we[gi] = wr && (sel == ((gi == 0) ? SEL_SCR0 : SEL_SCR1));
      assign scr_d[gi]  = scr_we[gi] ? wdata : scr_q[gi];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scr_q[gi] <= '0;
        else        scr_q[gi] <= scr_d[gi];
      end
    end
  endgenerate

  always_comb begin
    rst_d   = rst_q;
    led_d   = led_q;
    nib_d   = nib_q;
    map_d   = map_q;
    lock1_d = 1'b0;
    lock2_d = 1'b0;
    l2inv_d = 1'b0;
    if (wr) begin
      unique case (sel)
        SEL_RESET:  rst_d   = wdata[0];
        SEL_LED:    led_d   = |wdata;
        SEL_SYSCTL: nib_d   = wdata[NIB_W-1:0];
        SEL_MAP:    map_d   = wdata[0];
        SEL_LOCK1:  lock1_d = 1'b1;
        SEL_LOCK2:  lock2_d = 1'b1;
        SEL_L2INV:  l2inv_d = 1'b1;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q   <= 1'b0;
      led_q   <= 1'b0;
      nib_q   <= '0;
      map_q   <= 1'b0;
      lock1_q <= 1'b0;
      lock2_q <= 1'b0;
      l2inv_q <= 1'b0;
    end else begin
      rst_q   <= rst_d;
      led_q   <= led_d;
      nib_q   <= nib_d;
      map_q   <= map_d;
      lock1_q <= lock1_d;
      lock2_q <= lock2_d;
      l2inv_q <= l2inv_d;
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
(
  input  sel_e              sel,
  input  logic              rst_q,
  input  logic              led_q,
  input  logic [NIB_W-1:0]  nib_q,
  input  logic              map_q,
  input  logic [DATA_W-1:0] scr0_q,
  input  logic [DATA_W-1:0] scr1_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = RD_EMPTY;
    unique case (sel)
      SEL_RESET:  rdata = DATA_W'(rst_q);
      SEL_SCR0:   rdata = scr0_q;
      SEL_SCR1:   rdata = scr1_q;
      SEL_CPUCFG: rdata = ID_CPUCFG;
      SEL_FEAT:   rdata = ID_FEAT;
      SEL_STAT:   rdata = ID_STAT;
      SEL_XFEAT:  rdata = ID_XFEAT;
      SEL_LED:    rdata = DATA_W'(led_q);
      SEL_L2STAT: rdata = ID_L2STAT;
      SEL_SYSCTL: rdata = DATA_W'(nib_q);
      SEL_MAP:    rdata = DATA_W'(map_q);
      default:    rdata = RD_EMPTY;
    endcase
  end
endmodule

// File: rtl/sysctl_xlate.sv
module sysctl_xlate
  import sysctl_pkg::*;
#(
  parameter int LOW_W    = 5,
  parameter int PAGE_LSB = 12,
  parameter int SHIFT    = 7
) (
  input  logic              sparse,
  input  logic [WIN_W-1:0]  win_addr,
  output logic [PORT_W-1:0] isa_port
);
  localparam int PAGE_W = WIN_W - PAGE_LSB;

  logic [WIN_W-1:0]  page_bits;
  logic [WIN_W-1:0]  page_shift;
  logic [PORT_W-1:0] sparse_port;
  logic [PORT_W-1:0] flat_port;

  assign page_bits   = {win_addr[WIN_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
  assign page_shift  = page_bits >> SHIFT;
  assign sparse_port = PORT_W'(page_shift) | PORT_W'(win_addr[LOW_W-1:0]);
  assign flat_port   = win_addr[PORT_W-1:0];
  assign isa_port    = sparse ? sparse_port : flat_port;

  if (PAGE_W + LOW_W != PORT_W) begin : g_bad_geom
    initial $error("sparse geometry does not fill the port width");
  end
endmodule

// File: rtl/sysctl_regblk.sv
module sysctl_regblk
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       port_addr,
  input  logic              port_wr,
  input  logic [7:0]        port_wdata,
  output logic [7:0]        port_rdata,
  output logic              port_hit,
  input  logic [22:0]       win_addr,
  output logic [15:0]       isa_port,
  output logic              map_sparse,
  output logic              soft_reset,
  output logic              disk_led,
  output logic [3:0]        sysctl_nibble,
  output logic              lock1_pulse,
  output logic              lock2_pulse,
  output logic              l2_inval_pulse
);
  logic       rst_meta_n, rst_sync_n;
  sel_e       sel;
  logic [7:0] scr_q [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  sysctl_decode u_dec (
    .port_addr (port_addr),
    .sel       (sel),
    .hit       (port_hit)
  );

  sysctl_regs #(.NSCR(2)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel     (sel),
    .wr      (port_wr),
    .wdata   (port_wdata),
    .rst_q   (soft_reset),
    .led_q   (disk_led),
    .nib_q   (sysctl_nibble),
    .map_q   (map_sparse),
    .scr_q   (scr_q),
    .lock1_q (lock1_pulse),
    .lock2_q (lock2_pulse),
    .l2inv_q (l2_inval_pulse)
  );

  sysctl_rdmux u_rd (
    .sel    (sel),
    .rst_q  (soft_reset),
    .led_q  (disk_led),
    .nib_q  (sysctl_nibble),
    .map_q  (map_sparse),
    .scr0_q (scr_q[0]),
    .scr1_q (scr_q[1]),
    .rdata  (port_rdata)
  );

  sysctl_xlate u_xl (
    .sparse   (map_sparse),
    .win_addr (win_addr),
    .isa_port (isa_port)
  );
endmodule

// File: rtl/sysctl_regblk_chk.sv
module sysctl_regblk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] port_addr,
  input logic        port_wr,
  input logic [7:0]  port_wdata,
  input logic [22:0] win_addr,
  input logic [15:0] isa_port,
  input logic        map_sparse,
  input logic        soft_reset,
  input logic        disk_led,
  input logic        lock1_pulse,
  input logic        lock2_pulse,
  input logic        l2_inval_pulse
);
  p_reset_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(port_wr && port_addr == 16'h0092) |-> soft_reset == $past(port_wdata[0]));

  p_map_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(port_wr && port_addr == 16'h0850) |-> $stable(map_sparse));

  p_sparse_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    map_sparse |-> isa_port[4:0] == win_addr[4:0]);

  p_led_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(port_wr && port_addr == 16'h0808) |-> disk_led == (|$past(port_wdata)));

  p_lock1_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock1_pulse |-> $past(port_wr && port_addr == 16'h0810));

  p_lock2_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock2_pulse |-> $past(port_wr && port_addr == 16'h0812));

  p_l2inv_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    l2_inval_pulse |-> $past(port_wr && port_addr == 16'h0814));

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lock1_pulse, lock2_pulse, l2_inval_pulse}));
endmodule

bind sysctl_regblk sysctl_regblk_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .port_addr      (port_addr),
  .port_wr        (port_wr),
  .port_wdata     (port_wdata),
  .win_addr       (win_addr),
  .isa_port       (isa_port),
  .map_sparse     (map_sparse),
  .soft_reset     (soft_reset),
  .disk_led       (disk_led),
  .lock1_pulse    (lock1_pulse),
  .lock2_pulse    (lock2_pulse),
  .l2_inval_pulse (l2_inval_pulse)
);

// File: tb/sysctl_regblk_test.sv
module sysctl_regblk_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] port_addr = '0;
  logic        port_wr = 1'b0;
  logic [7:0]  port_wdata = '0;
  logic [7:0]  port_rdata;
  logic        port_hit;
  logic [22:0] win_addr = '0;
  logic [15:0] isa_port;
  logic        map_sparse, soft_reset, disk_led;
  logic [3:0]  sysctl_nibble;
  logic        lock1_pulse, lock2_pulse, l2_inval_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic       m_rst, m_led, m_map;
  logic [3:0] m_nib;
  logic [7:0] m_scr0, m_scr1;

  always #(CLK_P/2) clk = ~clk;

  sysctl_regblk uut (
    .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .port_wr(port_wr),
    .port_wdata(port_wdata), .port_rdata(port_rdata), .port_hit(port_hit),
    .win_addr(win_addr), .isa_port(isa_port), .map_sparse(map_sparse),
    .soft_reset(soft_reset), .disk_led(disk_led), .sysctl_nibble(sysctl_nibble),
    .lock1_pulse(lock1_pulse), .lock2_pulse(lock2_pulse),
    .l2_inval_pulse(l2_inval_pulse)
  );

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    case (a)
      16'h0092: return {7'b0, m_rst};
      16'h0398: return m_scr0;
      16'h0399: return m_scr1;
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h0804: return 8'h39;
      16'h0808: return {7'b0, m_led};
      16'h0818: return 8'h03;
      16'h081C: return {4'b0, m_nib};
      16'h0850: return {7'b0, m_map};
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic logic exp_hit(input logic [15:0] a);
    return (a == 16'h0092) || (a == 16'h0398) || (a == 16'h0399) ||
           (a >= 16'h0800 && a <= 16'h0851);
  endfunction

  function automatic logic [15:0] exp_port(input logic sp, input logic [22:0] w);
    logic [31:0] wide;
    wide = {9'b0, w};
    if (!sp) return w[15:0];
    return 16'((wide & 32'h1F) | ((wide & 32'h07FF_F000) >> 7));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_state(input string req);
    check(req, {31'b0, soft_reset}, {31'b0, m_rst});
    check(req, {31'b0, disk_led}, {31'b0, m_led});
    check(req, {28'b0, sysctl_nibble}, {28'b0, m_nib});
    check(req, {31'b0, map_sparse}, {31'b0, m_map});
  endtask

  task automatic do_read(input logic [15:0] a, input string req);
    @(negedge clk);
    port_addr = a;
    port_wr = 1'b0;
    #1;
    check(req, {24'b0, port_rdata}, {24'b0, exp_rd(a)});
    check(req, {31'b0, port_hit}, {31'b0, exp_hit(a)});
  endtask

  task automatic do_xlate(input logic [22:0] w, input string req);
    @(negedge clk);
    win_addr = w;
    #1;
    check(req, {16'b0, isa_port}, {16'b0, exp_port(m_map, w)});
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    port_addr = a;
    port_wdata = d;
    port_wr = 1'b1;
    @(posedge clk);
    #1;
    case (a)
      16'h0092: m_rst = d[0];
      16'h0398: m_scr0 = d;
      16'h0399: m_scr1 = d;
      16'h0808: m_led = |d;
      16'h081C: m_nib = d[3:0];
      16'h0850: m_map = d[0];
      default: ;
    endcase
    // R9: strobe in the cycle after the accepting edge
    check("R9", {29'b0, lock1_pulse, lock2_pulse, l2_inval_pulse},
          {29'b0, a == 16'h0810, a == 16'h0812, a == 16'h0814});
    check_state("R11 state after write");
    @(negedge clk);
    port_wr = 1'b0;
    @(posedge clk);
    #1;
    // R9: strobes last one cycle only
    check("R9 width", {29'b0, lock1_pulse, lock2_pulse, l2_inval_pulse}, 32'd0);
  endtask

  function automatic logic [15:0] pick_addr();
    logic [15:0] list [16] = '{16'h0092, 16'h0398, 16'h0399, 16'h0800,
      16'h0802, 16'h0803, 16'h0804, 16'h0808, 16'h0810, 16'h0812,
      16'h0814, 16'h0818, 16'h081C, 16'h0850, 16'h0851, 16'h0801};
    case ($urandom % 4)
      0, 1: return list[$urandom % 16];
      2:    return 16'h0800 + 16'($urandom % 16'h58);
      default: return 16'($urandom);
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_rst = 0; m_led = 0; m_map = 0; m_nib = 0; m_scr0 = 0; m_scr1 = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    #1;
    check_state("R1");
    check("R1 strobes", {29'b0, lock1_pulse, lock2_pulse, l2_inval_pulse}, 32'd0);
    do_read(16'h0398, "R1 scratch");
    do_read(16'h0399, "R1 scratch");

    // R3 identification bytes, writes ignored
    do_read(16'h0800, "R3"); do_read(16'h0802, "R3"); do_read(16'h0803, "R3");
    do_read(16'h0804, "R3"); do_read(16'h0818, "R3");
    do_write(16'h0800, 8'h00);
    do_read(16'h0800, "R3 write ignored");

    // R2 soft reset level
    do_write(16'h0092, 8'hFF); do_read(16'h0092, "R2 set");
    do_write(16'h0092, 8'hFE); do_read(16'h0092, "R2 clear");

    // R4 nibble masking
    do_write(16'h081C, 8'hA7); do_read(16'h081C, "R4");

    // R8 light
    do_write(16'h0808, 8'h80); do_read(16'h0808, "R8 nonzero");
    do_write(16'h0808, 8'h00); do_read(16'h0808, "R8 zero");

    // R10 scratch
    do_write(16'h0398, 8'h5A); do_write(16'h0399, 8'hC3);
    do_read(16'h0398, "R10"); do_read(16'h0399, "R10");

    // R9 strobes
    do_write(16'h0810, 8'h00); do_write(16'h0812, 8'h11); do_write(16'h0814, 8'h22);

    // R11 undecoded and unclaimed
    do_read(16'h0810, "R11 lock port"); do_read(16'h0851, "R11 top");
    do_read(16'h0852, "R11 outside"); do_read(16'h0093, "R11 outside");
    do_write(16'h0851, 8'h01);

    // R6 / R5 / R7 same-cycle map write and translation
    do_xlate(23'h7FF01F, "R6");
    @(negedge clk);
    port_addr = 16'h0850; port_wdata = 8'hFF; port_wr = 1'b1;
    win_addr = 23'h7FF0BF;
    #1;
    check("R6 old mode in write cycle", {16'b0, isa_port}, {16'b0, exp_port(1'b0, win_addr)});
    @(posedge clk);
    #1;
    m_map = 1'b1;
    check("R7 new mode after edge", {16'b0, isa_port}, {16'b0, exp_port(1'b1, win_addr)});
    @(negedge clk);
    port_wr = 1'b0;
    do_read(16'h0850, "R5");
    do_xlate(23'h000FFF, "R7");
    do_xlate(23'h400020, "R7");

    // random phase
    for (int i = 0; i < 600; i++) begin
      case ($urandom % 3)
        0: do_read(pick_addr(), "R11 random read");
        1: do_write(pick_addr(), 8'($urandom));
        default: do_xlate(23'($urandom), m_map ? "R7 random" : "R6 random");
      endcase
    end

    finish_run();
  end
endmodule